// File: doc/BRIEF.md
# Registered-Request Single-Port Memory Front End

This block puts one stage of request registers between a client and a single-port memory whose read data is registered. The client presents a request on a valid/ready port. Each request carries a write flag, an address and a write word. An accepted request is captured in the stage. On the next cycle the stage drives the memory's enable, write-enable, address and write-data pins. The stage's valid bit is the memory's enable, so the memory is idle whenever the stage is empty.

A read therefore passes through two registers. It is presented in cycle N, drives the memory in cycle N+1, and its word appears on the response port in cycle N+2. The response carries a one-cycle valid strobe. A write replaces the whole addressed word, because there are no byte lanes. It leaves the memory's read-data register undefined and raises no response. The memory never stalls, so the stage drains every cycle and the request port can always accept.

A behavioural model of the memory, parameterised by word width and depth, sits inside the block. The address width is the ceiling of log2 of the depth.

Top module: `sram_front`

## Requirements
- R1: After reset the response valid output is low, and the memory enable stays low until the first request has been accepted.
- R2: The request ready output is high in every cycle after reset.
- R3: A read request accepted in cycle N raises the response valid output in cycle N+2 only, for exactly one cycle, with the addressed word on the response data output.
- R4: A write stores the full DATA_W-bit write word at the addressed location, replacing every bit of the previous contents.
- R5: A write request never raises the response valid output.
- R6: Requests may be issued in every consecutive cycle. A read issued in the cycle right after a write to the same address returns the newly written word.
- R7: In any cycle that follows a cycle in which the memory was not enabled, the response data output is unchanged from the previous cycle.
- R8: Every address from 0 to DEPTH-1, using an address of $clog2(DEPTH) bits, selects its own word, and writing one address leaves the others intact.
- R9: Cycles with request valid low change neither the memory contents nor the response outputs, whatever the write flag, address and write data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | $clog2(DEPTH) | Word address |
| reqWdata | input | DATA_W | Word to store on a write |
| rspValid | output | 1 | Read word present, one cycle per read |
| rspData | output | DATA_W | Read word |

## Verification
The bench builds the block with DATA_W = 8 and DEPTH = 16. At that size every address can be written, read back and overwritten several times in a short run, including the top address 15, whose four address bits are all ones. The expected words come from an arithmetic pattern of the address and the pass number. A per-cycle pipeline model in the bench predicts the cycle in which each response must appear. Idle stretches with scrambled fields check that the held response word stays put and that the contents survive untouched.

// File: rtl/sram_front_pkg.sv
`timescale 1ns/1ps
package sram_front_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic load;   // capture address and write word into the stage
    logic memCe;  // stage holds a request: enable the memory
    logic memWe;  // held request is a write
  } frontStrobe_t;
endpackage

// File: rtl/sram_front_mem.sv
`timescale 1ns/1ps
module sram_front_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  // Single port; read word registered; a write leaves the read word undefined
  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) begin
        cells[addr] <= wdata;
        rdata       <= 'x;
      end else begin
        rdata <= cells[addr];
      end
    end
  end
endmodule

// File: rtl/sram_front_ctrl.sv
`timescale 1ns/1ps
module sram_front_ctrl
  import sram_front_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output frontStrobe_t strobe,
  output logic         rspValid
);
  logic stageValid;
  logic stageWe;
  logic rdPend;
  logic drain;
  logic accept;

  // The memory takes the held request every cycle, so the stage always drains
  assign drain    = stageValid;
  assign reqReady = !stageValid || drain;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageWe    <= 1'b0;
      rdPend     <= 1'b0;
    end else begin
      stageValid <= accept || (stageValid && !drain);
      if (accept) stageWe <= reqWrite;
      // the memory loads its read word on this edge
      rdPend <= stageValid && !stageWe;
    end
  end

  always_comb begin
    strobe.load  = accept;
    strobe.memCe = stageValid;
    strobe.memWe = stageWe;
  end

  assign rspValid = rdPend;
endmodule

// File: rtl/sram_front_dp.sv
`timescale 1ns/1ps
module sram_front_dp
  import sram_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  frontStrobe_t      strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              memCe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic [ADDR_W-1:0] stageAddr;
  logic [DATA_W-1:0] stageData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageAddr <= '0;
      stageData <= '0;
    end else if (strobe.load) begin
      stageAddr <= reqAddr;
      stageData <= reqWdata;
    end
  end

  assign memCe    = strobe.memCe;
  assign memWe    = strobe.memWe;
  assign memAddr  = stageAddr;
  assign memWdata = stageData;
endmodule

// File: rtl/sram_front.sv
`timescale 1ns/1ps
module sram_front
  import sram_front_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  frontStrobe_t      strobe;
  logic              memCe;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;

  sram_front_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  sram_front_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memCe    (memCe),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  sram_front_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk   (clk),
    .ce    (memCe),
    .we    (memWe),
    .addr  (memAddr),
    .wdata (memWdata),
    .rdata (rspData)
  );
endmodule

// File: rtl/sram_front_chk.sv
`timescale 1ns/1ps
module sram_front_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              memCe,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData
);
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady); // R2

  AST_CE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memCe |-> $past(reqValid)); // R1

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |-> ##2 rspValid); // R3

  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid, 2) && !$past(reqWrite, 2))); // R5

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(!memCe) |-> $stable(rspData)); // R7
endmodule

bind sram_front sram_front_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqWrite (reqWrite),
  .memCe    (memCe),
  .rspValid (rspValid),
  .rspData  (rspData)
);

// File: tb/sram_front_tb_top.sv
`timescale 1ns/1ps
module sram_front_tb_top;
  localparam int DW = 8;
  localparam int DP = 16;
  localparam int AW = $clog2(DP);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          rspValid;
  logic [DW-1:0] rspData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // bench model
  logic [DW-1:0] model [DP];
  int            opPipe [2];   // 0 none, 1 read, 2 write
  logic [DW-1:0] expPipe [2];
  logic [DW-1:0] lastData;
  bit            dataKnown = 1'b0;

  always #2 clk = ~clk;

  sram_front #(.DATA_W(DW), .DEPTH(DP)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    return DW'(a * 37 + pass * 91 + 5);
  endfunction

  // one cycle: check outputs for the request issued two cycles ago, then drive
  task automatic step(input bit v, input bit we, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    check(reqReady === 1'b1, "R2 ready", int'(reqReady), 1);
    case (opPipe[1])
      1: begin
        check(rspValid === 1'b1, "R3 rsp valid", int'(rspValid), 1);
        check(rspData === expPipe[1], "R4/R8 read data", int'(rspData), int'(expPipe[1]));
        lastData  = rspData;
        dataKnown = 1'b1;
      end
      2: begin
        check(rspValid === 1'b0, "R5 no rsp on write", int'(rspValid), 0);
        dataKnown = 1'b0;
      end
      default: begin
        check(rspValid === 1'b0, "R3 single pulse", int'(rspValid), 0);
        if (dataKnown)
          check(rspData === lastData, "R7/R9 data held", int'(rspData), int'(lastData));
      end
    endcase
    opPipe[1]  = opPipe[0];
    expPipe[1] = expPipe[0];
    opPipe[0]  = !v ? 0 : (we ? 2 : 1);
    expPipe[0] = model[a];
    if (v && we) model[a] = d;
    reqValid = v;
    reqWrite = we;
    reqAddr  = AW'(a);
    reqWdata = d;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DP; i++) model[i] = '0;
    opPipe[0] = 0; opPipe[1] = 0;
    expPipe[0] = '0; expPipe[1] = '0;
    repeat (4) @(negedge clk);
    check(rspValid === 1'b0, "R1 reset rsp", int'(rspValid), 0);
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(rspValid === 1'b0, "R1 idle after reset", int'(rspValid), 0);
    end
    // R8 R4: fill every address back-to-back
    for (int a = 0; a < DP; a++) step(1, 1, a, pat(a, 0));
    // R3 R6: read back every address in consecutive cycles
    for (int a = 0; a < DP; a++) step(1, 0, a, 8'h00);
    // read then idle: response held (R7)
    step(1, 0, 5, 8'h00);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 8'h00);
    // R9: scrambled fields with valid low
    for (int k = 0; k < 12; k++) step(0, 1, (k * 7) % DP, DW'(k * 29 + 3));
    for (int a = DP - 1; a >= 0; a--) step(1, 0, a, 8'h00);
    // R6: write then immediate read of the same address, full word replaced
    for (int a = 0; a < DP; a++) begin
      step(1, 1, a, ~pat(a, 1));
      step(1, 0, a, 8'h00);
    end
    // R8: second pass with gaps, odd addresses rewritten only
    for (int a = 1; a < DP; a += 2) step(1, 1, a, pat(a, 2));
    for (int a = 0; a < DP; a++) begin
      step(1, 0, a, 8'h00);
      step(0, 0, 0, 8'h00);
    end
    for (int k = 0; k < 4; k++) step(0, 0, 0, 8'h00);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule